// File: doc/BRIEF.md
# SECDED Memory Datapath with Hardware Scrubbing

This block sits between one requester and a synchronous memory that stores 72 bits per address. When protection is on, each stored word carries an 8-bit check code computed over its 64 data bits. A write that enables all eight bytes goes to memory in the cycle it is accepted. A write with only some bytes enabled becomes a read-merge-write: the old word is fetched and corrected, the new bytes are merged in, the code is recomputed and the whole word is written back.

Every read fetches the full 72-bit word and recomputes the code from the data. The XOR of the recomputed code and the stored code is the syndrome. A syndrome equal to one column of the parity-check matrix marks a single-bit error. The block corrects the word, returns it to the requester and, in the following cycle, writes the corrected word back to memory on its own. Any other nonzero syndrome is reported as uncorrectable. Each detected error pulses an event output that a separate logging block can capture. With protection off, the block passes data and byte enables straight through.

Top module: `ecc_memctl`

## Requirements
- R1: With ecc_en high, a write that enables all eight bytes is placed on the memory port in its acceptance cycle, with mem_we=1 and mem_be=9'h1FF. mem_wdata[63:0] carries the data and mem_wdata[71:64] the check code. Code bit j is the XOR of every data bit i whose column has bit j set. The column of data bit i is the i-th 8-bit vector of odd weight of at least 3, taking weights in increasing order and, within a weight, values in increasing order.
- R2: With ecc_en high, a write that enables fewer than eight bytes does three things in turn. In its acceptance cycle it issues a read of the same address. In the next cycle it holds req_ready low and leaves the memory port idle. In the cycle after that it writes the word in full (mem_be=9'h1FF): the enabled bytes are new, the other bytes come from the corrected old word, and the code is recomputed. req_ready is high again in the cycle after that write.
- R3: A read issues a memory read of the same address in its acceptance cycle. rsp_valid is high in the following cycle, with the 64-bit data in rsp_rdata.
- R4: With ecc_en high, a single-bit error in either a data bit or a check bit is corrected in rsp_rdata, and rsp_uncorr stays low.
- R5: After a read that corrected a single-bit error, the next cycle writes the corrected data and its fresh code to the same address with mem_be=9'h1FF. req_ready stays low until that write has been issued.
- R6: A nonzero syndrome that matches no column sets rsp_uncorr and returns the raw data, and no write-back follows. A partial write whose old word has such an error is dropped, and memory keeps the old word.
- R7: evt_valid pulses for one cycle for each detected error: in the response cycle of a read, or in the merge cycle of a partial write. evt_multi is 1 for an uncorrectable error and 0 for a corrected one. evt_row carries the top ROW_W address bits.
- R8: With ecc_en low, a read returns the stored data unchanged, with no event and no write-back. A write of any byte pattern takes a single cycle with mem_be={1'b0, req_be}, so the stored check byte is left untouched.
- R9: During reset, req_ready is high and mem_req, rsp_valid and evt_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | Protection enable, sampled when a request is accepted |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | DW/8 | Byte enables for writes |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DW | Read data, corrected when possible |
| rsp_uncorr | output | 1 | Read data holds an uncorrectable error |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_be | output | DW/8+1 | Byte enables; the top bit covers the check byte |
| mem_wdata | output | DW+CW | Data in the low bits, check code in the high bits |
| mem_rdata | input | DW+CW | Read word, valid one cycle after a read request |
| evt_valid | output | 1 | Error event pulse |
| evt_multi | output | 1 | 1 = uncorrectable, 0 = corrected |
| evt_row | output | ROW_W | Row of the failing address |

## Verification
The assertions take for granted that the memory returns a read word exactly one cycle after the request and that nothing else writes memory between that read and the write-back. The bench's memory model keeps to this. It applies injected bit flips only while no request is in flight, so the only writes the memory sees come from the block. The bench never corrupts more than two bits of a word. A double flip always gives an even-weight syndrome, so the expected uncorrectable result is certain and does not rely on which odd-weight vectors the code leaves unused.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RD,
      ST_MRG,
      ST_WB
   } ctl_st_e;

   function automatic int popc(input logic [15:0] x);
      int n;
      n = 0;
      for (int b = 0; b < 16; b++) n += int'(x[b]);
      return n;
   endfunction

   // number of odd-weight (>=3) vectors of width cw
   function automatic int odd_cols(input int cw);
      int n;
      n = 0;
      for (int v = 0; v < (1 << cw); v++) begin
         if (popc(v[15:0]) >= 3 && popc(v[15:0]) % 2 == 1) n++;
      end
      return n;
   endfunction

   // column idx of the parity-check matrix: weight ascending, value ascending
   function automatic logic [15:0] hcol(input int idx, input int cw);
      int n;
      n = 0;
      for (int w = 3; w <= cw; w += 2) begin
         for (int v = 0; v < (1 << cw); v++) begin
            if (popc(v[15:0]) == w) begin
               if (n == idx) return v[15:0];
               n++;
            end
         end
      end
      return '0;
   endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc #(
   parameter int DW = 64,
   parameter int CW = 8
) (
   input  logic [DW-1:0] d,
   output logic [CW-1:0] c
);
   localparam int NCOL = ecc_pkg::odd_cols(CW);

   if (CW > 16 || CW < 4) begin : g_bad_cw
      $error("ecc_enc: CW out of range");
   end
   if (NCOL < DW) begin : g_bad_dw
      $error("ecc_enc: too few odd-weight columns for DW");
   end

   logic [CW-1:0] col [DW];

   for (genvar i = 0; i < DW; i++) begin : g_col
      localparam logic [15:0] CV = ecc_pkg::hcol(i, CW);
      assign col[i] = CV[CW-1:0];
   end

   always_comb begin
      c = '0;
      for (int i = 0; i < DW; i++) c ^= col[i] & {CW{d[i]}};
   end
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec #(
   parameter int DW = 64,
   parameter int CW = 8
) (
   input  logic [DW+CW-1:0] word,
   input  logic             en,
   output logic [DW-1:0]    dout,
   output logic             single,
   output logic             multi
);
   logic [CW-1:0] cgen, syn;
   logic [DW-1:0] hit_d;
   logic [CW-1:0] hit_c;

   ecc_enc #(.DW(DW), .CW(CW)) u_enc (
      .d (word[DW-1:0]),
      .c (cgen)
   );

   assign syn = cgen ^ word[DW+CW-1:DW];

   for (genvar i = 0; i < DW; i++) begin : g_hd
      localparam logic [15:0] CV = ecc_pkg::hcol(i, CW);
      assign hit_d[i] = (syn == CV[CW-1:0]);
   end

   for (genvar j = 0; j < CW; j++) begin : g_hc
      localparam logic [CW-1:0] UV = CW'(1) << j;
      assign hit_c[j] = (syn == UV);
   end

   assign single = en & ((|hit_d) | (|hit_c));
   assign multi  = en & (syn != '0) & ~(|hit_d) & ~(|hit_c);
   assign dout   = en ? (word[DW-1:0] ^ hit_d) : word[DW-1:0];
endmodule

// File: rtl/ecc_bmerge.sv
module ecc_bmerge #(
   parameter int DW = 64
) (
   input  logic [DW-1:0]   old_d,
   input  logic [DW-1:0]   new_d,
   input  logic [DW/8-1:0] be,
   output logic [DW-1:0]   out_d
);
   localparam int BW = DW / 8;

   if (DW % 8 != 0) begin : g_bad_dw
      $error("ecc_bmerge: DW must be a multiple of 8");
   end

   for (genvar b = 0; b < BW; b++) begin : g_byte
      assign out_d[b*8 +: 8] = be[b] ? new_d[b*8 +: 8] : old_d[b*8 +: 8];
   end
endmodule

// File: rtl/ecc_memctl.sv
module ecc_memctl #(
   parameter int ADDR_W = 16,
   parameter int ROW_W  = 4,
   parameter int DW     = 64,
   parameter int CW     = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ecc_en,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DW/8-1:0]     req_be,
   input  logic [DW-1:0]       req_wdata,
   output logic                rsp_valid,
   output logic [DW-1:0]       rsp_rdata,
   output logic                rsp_uncorr,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DW/8:0]       mem_be,
   output logic [DW+CW-1:0]    mem_wdata,
   input  logic [DW+CW-1:0]    mem_rdata,
   output logic                evt_valid,
   output logic                evt_multi,
   output logic [ROW_W-1:0]    evt_row
);
   import ecc_pkg::*;

   localparam int BW = DW / 8;
   localparam int MW = DW + CW;

   if (DW % 8 != 0) begin : g_bad_dw
      $error("ecc_memctl: DW must be a multiple of 8");
   end
   if (ROW_W < 1 || ROW_W > ADDR_W) begin : g_bad_row
      $error("ecc_memctl: ROW_W out of range");
   end

   ctl_st_e           st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DW-1:0]     wdata_q;
   logic [BW-1:0]     be_q;
   logic              en_q;
   logic [MW-1:0]     wb_q;

   logic [DW-1:0]     fix_d, mrg_d, enc_in;
   logic [CW-1:0]     enc_c;
   logic              err_s, err_m;
   logic              acc, rmw_need;

   assign req_ready = (st_q == ST_IDLE);
   assign acc       = req_valid & req_ready;
   assign rmw_need  = ecc_en & ~(&req_be);

   ecc_dec #(.DW(DW), .CW(CW)) u_dec (
      .word   (mem_rdata),
      .en     (en_q),
      .dout   (fix_d),
      .single (err_s),
      .multi  (err_m)
   );

   ecc_bmerge #(.DW(DW)) u_mrg (
      .old_d (fix_d),
      .new_d (wdata_q),
      .be    (be_q),
      .out_d (mrg_d)
   );

   // one encoder shared by the direct-write, merge and scrub paths
   always_comb begin
      case (st_q)
         ST_MRG:  enc_in = mrg_d;
         ST_RD:   enc_in = fix_d;
         default: enc_in = req_wdata;
      endcase
   end

   ecc_enc #(.DW(DW), .CW(CW)) u_enc (
      .d (enc_in),
      .c (enc_c)
   );

   // memory port
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = req_addr;
      mem_be    = '0;
      mem_wdata = {enc_c, req_wdata};
      case (st_q)
         ST_IDLE: begin
            if (req_valid) begin
               mem_req = 1'b1;
               if (req_write && !rmw_need) begin
                  mem_we = 1'b1;
                  mem_be = ecc_en ? '1 : {1'b0, req_be};
               end
            end
         end
         ST_WB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = addr_q;
            mem_be    = '1;
            mem_wdata = wb_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         be_q    <= '0;
         en_q    <= 1'b0;
         wb_q    <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (acc) begin
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
                  be_q    <= req_be;
                  en_q    <= ecc_en;
                  if (!req_write)    st_q <= ST_RD;
                  else if (rmw_need) st_q <= ST_MRG;
               end
            end
            ST_RD: begin
               wb_q <= {enc_c, fix_d};
               st_q <= err_s ? ST_WB : ST_IDLE;
            end
            ST_MRG: begin
               wb_q <= {enc_c, mrg_d};
               st_q <= err_m ? ST_IDLE : ST_WB;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign rsp_valid  = (st_q == ST_RD);
   assign rsp_rdata  = fix_d;
   assign rsp_uncorr = (st_q == ST_RD) & err_m;
   assign evt_valid  = ((st_q == ST_RD) | (st_q == ST_MRG)) & (err_s | err_m);
   assign evt_multi  = err_m;
   assign evt_row    = addr_q[ADDR_W-1 -: ROW_W];

   AST_FULL_WR_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_write && ecc_en && (&req_be)) |-> (mem_req && mem_we && (&mem_be))); // R1
   AST_RMW_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_write && rmw_need) |-> (mem_req && !mem_we)); // R2
   AST_RMW_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_write && rmw_need) |=> (!req_ready && !mem_req)); // R2
   AST_RD_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !req_write) |=> rsp_valid); // R3
   AST_SCRUB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && evt_valid && !evt_multi) |=> (mem_req && mem_we && (&mem_be))); // R5
   AST_NO_WB_UNCORR: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_multi) |=> req_ready); // R6
   AST_UNCORR_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_uncorr |-> (evt_valid && evt_multi)); // R7
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> en_q); // R8
endmodule

// File: tb/sim_ecc_memctl.sv
module sim_ecc_memctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ecc_en = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_be = '0;
   logic [63:0] req_wdata = '0;
   logic        rsp_valid;
   logic [63:0] rsp_rdata;
   logic        rsp_uncorr;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr;
   logic [8:0]  mem_be;
   logic [71:0] mem_wdata;
   logic [71:0] mem_rdata;
   logic        evt_valid, evt_multi;
   logic [3:0]  evt_row;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   ecc_memctl u0 (
      .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_uncorr(rsp_uncorr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .evt_valid(evt_valid), .evt_multi(evt_multi), .evt_row(evt_row)
   );

   // behavioural memory: one-cycle read latency, flips injected in the same process
   logic [71:0] mem_m [256];
   logic [71:0] rd_q = '0;
   logic        inj_go = 1'b0;
   logic [7:0]  inj_a = '0;
   logic [71:0] inj_m = '0;
   assign mem_rdata = rd_q;

   always @(posedge clk) begin
      if (inj_go) mem_m[inj_a] <= mem_m[inj_a] ^ inj_m;
      else if (mem_req) begin
         if (mem_we) begin
            for (int b = 0; b < 9; b++)
               if (mem_be[b]) mem_m[mem_addr[7:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
         end else rd_q <= mem_m[mem_addr[7:0]];
      end
   end

   logic [63:0] gold [256];

   function automatic logic [7:0] ref_code(input logic [63:0] d);
      logic [7:0] cols [64];
      logic [7:0] c;
      int k;
      k = 0;
      c = '0;
      for (int w = 3; w <= 7; w += 2)
         for (int v = 0; v < 256; v++)
            if (k < 64 && $countones(v[7:0]) == w) begin
               cols[k] = v[7:0];
               k++;
            end
      for (int i = 0; i < 64; i++) if (d[i]) c ^= cols[i];
      return c;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic inject(input logic [7:0] a, input logic [71:0] m);
      @(negedge clk);
      inj_a = a; inj_m = m; inj_go = 1'b1;
      @(negedge clk);
      inj_go = 1'b0;
   endtask

   // drop: partial write whose old word is uncorrectable
   task automatic wr(input logic [15:0] a, input logic [63:0] d, input logic [7:0] be,
                     input logic en, input bit drop);
      logic [63:0] m;
      logic [8:0]  xbe;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be; ecc_en = en;
      #1;
      chk(req_ready, "R2 ready in idle", 72'(req_ready), 72'(1));
      if (!en || be == 8'hFF) begin
         xbe = en ? 9'h1FF : {1'b0, be};
         chk(mem_req && mem_we && mem_addr == a, en ? "R1 write now" : "R8 write now",
             72'({mem_req, mem_we, mem_addr}), 72'({2'b11, a}));
         chk(mem_be == xbe, en ? "R1 byte enables" : "R8 byte enables", 72'(mem_be), 72'(xbe));
         chk(mem_wdata[63:0] == d, "R1 data", 72'(mem_wdata[63:0]), 72'(d));
         if (en) chk(mem_wdata[71:64] == ref_code(d), "R1 code", 72'(mem_wdata[71:64]), 72'(ref_code(d)));
         @(posedge clk); @(negedge clk);
         req_valid = 1'b0;
         for (int b = 0; b < 8; b++) if (be[b]) gold[a[7:0]][b*8 +: 8] = d[b*8 +: 8];
      end else begin
         chk(mem_req && !mem_we && mem_addr == a, "R2 read first",
             72'({mem_req, mem_we, mem_addr}), 72'({2'b10, a}));
         @(posedge clk); @(negedge clk);
         req_valid = 1'b0;
         chk(!req_ready && !mem_req, "R2 merge stall", 72'({req_ready, mem_req}), 72'(0));
         if (drop) begin
            chk(evt_valid && evt_multi, "R7 merge event", 72'({evt_valid, evt_multi}), 72'(3));
            @(posedge clk); @(negedge clk);
            chk(req_ready && !mem_req, "R6 partial write dropped", 72'({req_ready, mem_req}), 72'(2));
         end else begin
            for (int b = 0; b < 8; b++) m[b*8 +: 8] = be[b] ? d[b*8 +: 8] : gold[a[7:0]][b*8 +: 8];
            @(posedge clk); @(negedge clk);
            chk(mem_req && mem_we && mem_addr == a && mem_be == 9'h1FF, "R2 merged write",
                72'({mem_req, mem_we, mem_be, mem_addr}), 72'({2'b11, 9'h1FF, a}));
            chk(mem_wdata == {ref_code(m), m}, "R2 merged word", mem_wdata, {ref_code(m), m});
            gold[a[7:0]] = m;
            @(posedge clk); @(negedge clk);
            chk(req_ready, "R2 ready after write", 72'(req_ready), 72'(1));
         end
      end
   endtask

   // kind: 0 clean, 1 single-bit, 2 uncorrectable
   task automatic rd(input logic [15:0] a, input logic en, input int kind, input logic [63:0] xd);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; ecc_en = en;
      #1;
      chk(mem_req && !mem_we && mem_addr == a, "R3 read issue",
          72'({mem_req, mem_we, mem_addr}), 72'({2'b10, a}));
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid, "R3 response valid", 72'(rsp_valid), 72'(1));
      chk(rsp_rdata == xd, kind == 1 ? "R4 corrected data" : (kind == 2 ? "R6 raw data" : "R3 data"),
          72'(rsp_rdata), 72'(xd));
      chk(rsp_uncorr == (kind == 2), "R6 uncorrectable flag", 72'(rsp_uncorr), 72'(kind == 2));
      chk(evt_valid == (kind != 0), en ? "R7 event pulse" : "R8 no event", 72'(evt_valid), 72'(kind != 0));
      if (kind != 0) begin
         chk(evt_multi == (kind == 2), "R7 event type", 72'(evt_multi), 72'(kind == 2));
         chk(evt_row == a[15:12], "R7 event row", 72'(evt_row), 72'(a[15:12]));
      end
      @(posedge clk); @(negedge clk);
      if (kind == 1) begin
         chk(mem_req && mem_we && mem_addr == a && mem_be == 9'h1FF, "R5 scrub write",
             72'({mem_req, mem_we, mem_be, mem_addr}), 72'({2'b11, 9'h1FF, a}));
         chk(mem_wdata == {ref_code(xd), xd}, "R5 scrub word", mem_wdata, {ref_code(xd), xd});
         @(posedge clk); @(negedge clk);
      end
      chk(req_ready && !mem_req, kind == 2 ? "R6 no write-back" : "R8 idle after read",
          72'({req_ready, mem_req}), 72'(2));
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] d1, d2, bad;
      logic [71:0] saved;
      d1 = 64'h0123_4567_89AB_CDEF;
      d2 = 64'hFEDC_BA98_7654_3210;
      for (int i = 0; i < 256; i++) gold[i] = '0;

      repeat (2) @(negedge clk);
      chk(req_ready && !mem_req && !rsp_valid && !evt_valid, "R9 reset state",
          72'({req_ready, mem_req, rsp_valid, evt_valid}), 72'(8));
      rst_n = 1'b1;

      wr(16'hA012, d1, 8'hFF, 1'b1, 0);
      rd(16'hA012, 1'b1, 0, d1);

      inject(8'h12, 72'(1) << 5);
      rd(16'hA012, 1'b1, 1, d1);
      chk(mem_m[8'h12] == {ref_code(d1), d1}, "R5 memory repaired", mem_m[8'h12], {ref_code(d1), d1});

      inject(8'h12, 72'(1) << 66);
      rd(16'hA012, 1'b1, 1, d1);
      chk(mem_m[8'h12] == {ref_code(d1), d1}, "R4 check-bit repaired", mem_m[8'h12], {ref_code(d1), d1});

      inject(8'h12, (72'(1) << 3) | (72'(1) << 40));
      bad = d1 ^ ((64'(1) << 3) | (64'(1) << 40));
      rd(16'hA012, 1'b1, 2, bad);
      saved = mem_m[8'h12];
      chk(saved[63:0] == bad, "R6 memory left as is", 72'(saved[63:0]), 72'(bad));
      wr(16'hA012, d2, 8'h0F, 1'b1, 1);
      chk(mem_m[8'h12] == saved, "R6 dropped write keeps memory", mem_m[8'h12], saved);

      wr(16'h5034, d2, 8'hFF, 1'b1, 0);
      wr(16'h5034, d1, 8'h3C, 1'b1, 0);
      rd(16'h5034, 1'b1, 0, gold[8'h34]);

      saved = mem_m[8'h34];
      wr(16'h5034, d1, 8'hF0, 1'b0, 0);
      chk(mem_m[8'h34][71:64] == saved[71:64], "R8 check byte untouched",
          72'(mem_m[8'h34][71:64]), 72'(saved[71:64]));
      rd(16'h5034, 1'b0, 0, gold[8'h34]);
      chk(mem_m[8'h34][71:64] == saved[71:64], "R8 no scrub", 72'(mem_m[8'h34][71:64]), 72'(saved[71:64]));

      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule